// File: doc/BRIEF.md
# Hot-Swap Gate Control Sequencer

This block decides, one clock at a time, whether the gate of an external pass transistor is driven. It takes clean synchronous flags for an undervoltage condition, for internal supply lockout release and for a power-good confirmation level. It also takes a digitized current-sense sample and the retry enable bits held in a neighbouring register bank. It drives the gate enable and a power-good output. It also emits single-cycle pulses that the register bank uses to set its present and fault bits.

A base delay of tD clock cycles (programmable, with 0 treated as 1) comes before every turn-on. Once the gate is on, a confirmation window of 4·tD cycles opens. If the power-good confirmation does not arrive inside it, the gate is shut off and a power-bad fault is raised. After an undervoltage fault or a power-bad fault, the gate turns on again only if that fault's own retry permission allows it. A single reloadable down-counter times both the delay and the window. While the gate is off, a sense sample at or above a fixed short threshold code raises a transistor-short fault.

Top module: `hsgate_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `gate_en`, `pwr_good` and every set/clear pulse output are 0.
- R2: When `uv_flag` goes high while `lock_ok` is high, on the next cycle `gate_en` and `pwr_good` are 0 and `set_uv_pres` and `set_uv_flt` pulse. The gate stays off while `uv_flag` stays high.
- R3: If `uv_flag` is already high in the first cycle that `lock_ok` is high, `set_uv_pres` and `set_uv_flt` pulse on the next cycle.
- R4: With the gate off and turn-on allowed, `gate_en` rises on the (tD+1)-th rising edge, counting the first edge that samples the enabling condition, where tD = max(`td_cycles`, 1).
- R5: After an undervoltage fault with `uv_retry_en` = 0, the gate stays off after `uv_flag` clears. With `uv_retry_en` = 1, it follows R4.
- R6: `pwr_good` rises together with `gate_en` on turn-on, and falls whenever the gate is shut off.
- R7: If `pgi_low` is sampled high on any of the first 4·tD edges after `gate_en` rises, the gate stays on. Later changes of `pgi_low` then have no effect.
- R8: If `pgi_low` stays low for those 4·tD edges, then after the 4·tD-th edge `gate_en` and `pwr_good` are 0 and `set_pb_pres` and `set_pb_flt` pulse. `clr_pb_pres` pulses on the following cycle.
- R9: After a power-bad shutdown, the gate restarts only while `pgi_low` = 1 and (`pb_retry_en` = 1 or `pb_fault_bit` = 0). It then follows the R4 delay and a fresh R7/R8 window. Otherwise it stays off.
- R10: A sample with `sense_valid` = 1 and `sense_code` >= SHORT_CODE (default 16), taken while `gate_en` is 0, pulses `set_sh_pres` and `set_sh_flt` on the next cycle. Samples below the code, or taken while the gate is on, give no pulse.
- R11: The undervoltage and power-bad set pulses last exactly one cycle per event.
- R12: While `lock_ok` is 0, the gate is off on the next cycle and stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_ok | input | 1 | Internal supply lockout released |
| uv_flag | input | 1 | Undervoltage condition present |
| pgi_low | input | 1 | Downstream power-good confirmation (1 = confirmed) |
| uv_retry_en | input | 1 | Undervoltage auto-retry permission |
| pb_retry_en | input | 1 | Power-bad auto-retry permission |
| pb_fault_bit | input | 1 | Latched power-bad fault bit from the register bank |
| td_cycles | input | CNT_W | Base delay tD in clock cycles (0 acts as 1) |
| sense_valid | input | 1 | New current-sense sample this cycle |
| sense_code | input | SENSE_W | Current-sense sample |
| gate_en | output | 1 | Gate drive enable |
| pwr_good | output | 1 | Power-good output |
| set_uv_pres | output | 1 | Pulse: set undervoltage present |
| set_uv_flt | output | 1 | Pulse: set undervoltage fault |
| set_pb_pres | output | 1 | Pulse: set power-bad present |
| set_pb_flt | output | 1 | Pulse: set power-bad fault |
| clr_pb_pres | output | 1 | Pulse: clear power-bad present once gate is off |
| set_sh_pres | output | 1 | Pulse: set transistor-short present |
| set_sh_flt | output | 1 | Pulse: set transistor-short fault |

## Verification
Some rules hold on every cycle, and the assertions check these. An undervoltage or a missing lockout forces the gate off, and the undervoltage and power-bad pulses last one cycle. A power-bad pulse coincides with the gate and power-good being low. A short pulse follows only a sample taken with the gate off. Every gate rise comes with power-good and follows a cycle free of undervoltage. Other behaviour depends on exact cycle counts and retry history, and only the bench scenarios can show it: the tD+1 turn-on latency, including tD = 0, the 4·tD confirmation window at its last edge and one edge beyond, the blocked and permitted retries after each fault type, and the code threshold boundary.

// File: rtl/hsgate_pkg.sv
package hsgate_pkg;
  typedef enum logic [4:0] {
    ST_IDLE  = 5'b00001,
    ST_DELAY = 5'b00010,
    ST_CHECK = 5'b00100,
    ST_GOOD  = 5'b01000,
    ST_FAULT = 5'b10000
  } hsg_state_e;
endpackage

// File: rtl/hsgate_timer.sv
module hsgate_timer #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         cnt_zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign cnt_zero = (cnt == '0);
endmodule

// File: rtl/hsgate_fsm.sv
module hsgate_fsm
  import hsgate_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_ok,
  input  logic             uv_flag,
  input  logic             pgi_low,
  input  logic             uv_retry_en,
  input  logic             pb_retry_en,
  input  logic             pb_fault_bit,
  input  logic [CNT_W-1:0] td_cycles,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W+1:0] tmr_val,
  output logic             nxt_on,
  output logic             uv_event,
  output logic             pb_timeout
);
  localparam int TW = CNT_W + 2;

  hsg_state_e    st, nxt;
  logic          uv_q, lock_q, tripped;
  logic [TW-1:0] td_eff;

  always_comb begin
    if (td_cycles == '0) td_eff = {{(TW-1){1'b0}}, 1'b1};
    else                 td_eff = {2'b00, td_cycles};
  end

  // A new undervoltage event: fresh rise, or present when lockout releases
  assign uv_event   = lock_ok & uv_flag & (~uv_q | ~lock_q);
  assign pb_timeout = lock_ok & ~uv_flag & (st == ST_CHECK) & ~pgi_low & tmr_zero;

  always_comb begin
    nxt = st;
    if (!lock_ok || uv_flag) begin
      nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE:  if (!tripped || uv_retry_en) nxt = ST_DELAY;
        ST_DELAY: if (tmr_zero) nxt = ST_CHECK;
        ST_CHECK: begin
          if (pgi_low)       nxt = ST_GOOD;
          else if (tmr_zero) nxt = ST_FAULT;
        end
        ST_GOOD:  nxt = ST_GOOD;
        ST_FAULT: if (pgi_low && (pb_retry_en || !pb_fault_bit)) nxt = ST_DELAY;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tmr_load = (nxt != st) && ((nxt == ST_DELAY) || (nxt == ST_CHECK));
    if (nxt == ST_CHECK) tmr_val = (td_eff << 2) - 1'b1;
    else                 tmr_val = td_eff - 1'b1;
    nxt_on = (nxt == ST_CHECK) || (nxt == ST_GOOD);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      uv_q    <= 1'b0;
      lock_q  <= 1'b0;
      tripped <= 1'b0;
    end else begin
      st     <= nxt;
      uv_q   <= uv_flag;
      lock_q <= lock_ok;
      if (uv_event)                             tripped <= 1'b1;
      else if (st == ST_IDLE && nxt == ST_DELAY) tripped <= 1'b0;
    end
  end
endmodule

// File: rtl/hsgate_short_det.sv
module hsgate_short_det #(
  parameter int               SENSE_W    = 10,
  parameter logic [SENSE_W-1:0] SHORT_CODE = 16
) (
  input  logic               sense_valid,
  input  logic [SENSE_W-1:0] sense_code,
  input  logic               gate_on,
  output logic               hit
);
  assign hit = sense_valid & ~gate_on & (sense_code >= SHORT_CODE);
endmodule

// File: rtl/hsgate_seq.sv
module hsgate_seq #(
  parameter int                 CNT_W      = 16,
  parameter int                 SENSE_W    = 10,
  parameter logic [SENSE_W-1:0] SHORT_CODE = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lock_ok,
  input  logic               uv_flag,
  input  logic               pgi_low,
  input  logic               uv_retry_en,
  input  logic               pb_retry_en,
  input  logic               pb_fault_bit,
  input  logic [CNT_W-1:0]   td_cycles,
  input  logic               sense_valid,
  input  logic [SENSE_W-1:0] sense_code,
  output logic               gate_en,
  output logic               pwr_good,
  output logic               set_uv_pres,
  output logic               set_uv_flt,
  output logic               set_pb_pres,
  output logic               set_pb_flt,
  output logic               clr_pb_pres,
  output logic               set_sh_pres,
  output logic               set_sh_flt
);
  localparam int TW = CNT_W + 2;

  logic          tmr_load, tmr_zero, nxt_on, uv_event, pb_timeout, sh_hit;
  logic [TW-1:0] tmr_val;

  hsgate_timer #(.W(TW)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .cnt_zero(tmr_zero)
  );

  hsgate_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .lock_ok(lock_ok), .uv_flag(uv_flag), .pgi_low(pgi_low),
    .uv_retry_en(uv_retry_en), .pb_retry_en(pb_retry_en), .pb_fault_bit(pb_fault_bit),
    .td_cycles(td_cycles), .tmr_zero(tmr_zero), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .nxt_on(nxt_on), .uv_event(uv_event), .pb_timeout(pb_timeout)
  );

  hsgate_short_det #(.SENSE_W(SENSE_W), .SHORT_CODE(SHORT_CODE)) u_short (
    .sense_valid(sense_valid), .sense_code(sense_code), .gate_on(gate_en), .hit(sh_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en     <= 1'b0;
      pwr_good    <= 1'b0;
      set_uv_pres <= 1'b0;
      set_uv_flt  <= 1'b0;
      set_pb_pres <= 1'b0;
      set_pb_flt  <= 1'b0;
      clr_pb_pres <= 1'b0;
      set_sh_pres <= 1'b0;
      set_sh_flt  <= 1'b0;
    end else begin
      gate_en     <= nxt_on;
      pwr_good    <= nxt_on;
      set_uv_pres <= uv_event;
      set_uv_flt  <= uv_event;
      set_pb_pres <= pb_timeout;
      set_pb_flt  <= pb_timeout;
      clr_pb_pres <= set_pb_pres;
      set_sh_pres <= sh_hit;
      set_sh_flt  <= sh_hit;
    end
  end
endmodule

// File: rtl/hsgate_seq_chk.sv
module hsgate_seq_chk (
  input logic clk,
  input logic rst,
  input logic lock_ok,
  input logic uv_flag,
  input logic gate_en,
  input logic pwr_good,
  input logic set_uv_flt,
  input logic set_pb_flt,
  input logic set_sh_flt
);
  p_reset_off_r1: assert property (@(posedge clk)
    rst |=> (!gate_en && !pwr_good && !set_uv_flt && !set_pb_flt && !set_sh_flt));

  p_uv_forces_off_r2: assert property (@(posedge clk) disable iff (rst)
    (lock_ok && uv_flag) |=> (!gate_en && !pwr_good));

  p_uv_rise_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    ($rose(uv_flag) && lock_ok) |=> set_uv_flt);

  p_uv_single_r11: assert property (@(posedge clk) disable iff (rst)
    set_uv_flt |=> !set_uv_flt);

  p_pb_single_r11: assert property (@(posedge clk) disable iff (rst)
    set_pb_flt |=> !set_pb_flt);

  p_pb_off_r8: assert property (@(posedge clk) disable iff (rst)
    set_pb_flt |-> (!gate_en && !pwr_good));

  p_lock_off_r12: assert property (@(posedge clk) disable iff (rst)
    !lock_ok |=> !gate_en);

  p_rise_clean_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en) |-> (!$past(uv_flag) && $past(lock_ok)));

  p_rise_pg_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_en) |-> pwr_good);

  p_short_off_r10: assert property (@(posedge clk) disable iff (rst)
    set_sh_flt |-> !$past(gate_en));
endmodule

bind hsgate_seq hsgate_seq_chk u_chk (
  .clk(clk), .rst(rst), .lock_ok(lock_ok), .uv_flag(uv_flag), .gate_en(gate_en),
  .pwr_good(pwr_good), .set_uv_flt(set_uv_flt), .set_pb_flt(set_pb_flt),
  .set_sh_flt(set_sh_flt)
);

// File: tb/hsgate_seq_tb.sv
module hsgate_seq_tb;
  localparam int CW = 8;
  localparam int SW = 10;
  localparam logic [SW-1:0] SC = 10'd16;

  logic clk = 1'b0;
  logic rst, lock_ok, uv_flag, pgi_low, uv_retry_en, pb_retry_en, pb_fault_bit;
  logic [CW-1:0] td_cycles;
  logic sense_valid;
  logic [SW-1:0] sense_code;
  logic gate_en, pwr_good, set_uv_pres, set_uv_flt, set_pb_pres, set_pb_flt;
  logic clr_pb_pres, set_sh_pres, set_sh_flt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hsgate_seq #(.CNT_W(CW), .SENSE_W(SW), .SHORT_CODE(SC)) u_dut (
    .clk(clk), .rst(rst), .lock_ok(lock_ok), .uv_flag(uv_flag), .pgi_low(pgi_low),
    .uv_retry_en(uv_retry_en), .pb_retry_en(pb_retry_en), .pb_fault_bit(pb_fault_bit),
    .td_cycles(td_cycles), .sense_valid(sense_valid), .sense_code(sense_code),
    .gate_en(gate_en), .pwr_good(pwr_good), .set_uv_pres(set_uv_pres),
    .set_uv_flt(set_uv_flt), .set_pb_pres(set_pb_pres), .set_pb_flt(set_pb_flt),
    .clr_pb_pres(clr_pb_pres), .set_sh_pres(set_sh_pres), .set_sh_flt(set_sh_flt)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int f_td(int td);
    return (td == 0) ? 1 : td;
  endfunction
  function automatic int f_lat(int td);
    return f_td(td) + 1;
  endfunction
  function automatic int f_win(int td);
    return 4 * f_td(td);
  endfunction

  task automatic measure_on(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!gate_en && n < 200);
  endtask

  task automatic measure_pb(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (!set_pb_flt && n < 200);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    int seed;
    seed = $urandom(32'd20240611);
    rst = 1'b1; lock_ok = 1'b0; uv_flag = 1'b0; pgi_low = 1'b0;
    uv_retry_en = 1'b0; pb_retry_en = 1'b0; pb_fault_bit = 1'b0;
    td_cycles = 8'd3; sense_valid = 1'b0; sense_code = '0;
    @(negedge clk);
    repeat (3) step();
    chk("R1 gate in reset", int'(gate_en), 0);
    chk("R1 pwr_good in reset", int'(pwr_good), 0);
    chk("R1 uv pulse in reset", int'(set_uv_flt), 0);
    rst = 1'b0;
    step();
    chk("R12 gate with lockout", int'(gate_en), 0);

    // R3: undervoltage present at lockout release
    uv_flag = 1'b1; lock_ok = 1'b1;
    step();
    chk("R3 uv fault at release", int'(set_uv_flt), 1);
    chk("R3 uv present at release", int'(set_uv_pres), 1);
    step();
    chk("R11 uv pulse single", int'(set_uv_flt), 0);

    // R5: no retry permission keeps gate off
    uv_flag = 1'b0;
    repeat (20) step();
    chk("R5 gate stays off", int'(gate_en), 0);

    // R4/R6: retry enabled
    uv_retry_en = 1'b1;
    measure_on(n);
    chk("R4 turn-on latency td=3", n, f_lat(3));
    chk("R6 pwr_good with gate", int'(pwr_good), 1);

    // R8: window expires
    measure_pb(n);
    chk("R8 window length td=3", n, f_win(3));
    chk("R8 gate off at timeout", int'(gate_en), 0);
    chk("R6 pwr_good off at timeout", int'(pwr_good), 0);
    chk("R8 pb present pulse", int'(set_pb_pres), 1);
    step();
    chk("R8 pb present clear", int'(clr_pb_pres), 1);
    chk("R11 pb pulse single", int'(set_pb_flt), 0);

    // R9: retry blocked, then allowed by clearing fault bit
    pb_fault_bit = 1'b1; pgi_low = 1'b1;
    repeat (20) step();
    chk("R9 retry blocked", int'(gate_en), 0);
    pb_fault_bit = 1'b0;
    measure_on(n);
    chk("R9 retry after clear latency", n, f_lat(3));
    step();
    pgi_low = 1'b0;
    repeat (30) step();
    chk("R7 stays on after confirm", int'(gate_en), 1);

    // R10: short samples
    sense_valid = 1'b1; sense_code = 10'd1023;
    step();
    chk("R10 no short while on", int'(set_sh_flt), 0);
    uv_flag = 1'b1;
    step();
    chk("R2 gate off on uv", int'(gate_en), 0);
    chk("R2 pwr_good off on uv", int'(pwr_good), 0);
    chk("R2 uv fault pulse", int'(set_uv_flt), 1);
    chk("R10 sample taken while on", int'(set_sh_flt), 0);
    step();
    chk("R10 short while off", int'(set_sh_flt), 1);
    chk("R10 short present", int'(set_sh_pres), 1);
    sense_code = SC - 1'b1;
    step();
    chk("R10 below code", int'(set_sh_flt), 0);
    sense_code = SC;
    step();
    chk("R10 at code", int'(set_sh_flt), 1);
    sense_valid = 1'b0;
    repeat (5) step();
    chk("R2 held off during uv", int'(gate_en), 0);

    // R9: retry via auto-retry bit
    uv_flag = 1'b0;
    measure_on(n);
    chk("R5 retry enabled latency", n, f_lat(3));
    measure_pb(n);
    chk("R8 second window", n, f_win(3));
    step();
    pb_fault_bit = 1'b1; pb_retry_en = 1'b1; pgi_low = 1'b1;
    measure_on(n);
    chk("R9 auto-retry latency", n, f_lat(3));

    // R12 and tD = 0
    td_cycles = 8'd0;
    lock_ok = 1'b0; pgi_low = 1'b0;
    step();
    chk("R12 lockout forces off", int'(gate_en), 0);
    repeat (4) step();
    chk("R12 stays off", int'(gate_en), 0);
    lock_ok = 1'b1;
    measure_on(n);
    chk("R4 latency td=0", n, f_lat(0));
    measure_pb(n);
    chk("R8 window td=0", n, f_win(0));

    // Random window trials
    pb_fault_bit = 1'b1; pb_retry_en = 1'b0;
    for (int t = 0; t < 24; t++) begin
      int tdv, d, m;
      bit pb_seen, good;
      tdv = 1 + int'($urandom % 6);
      d = 1 + int'($urandom % (5 * tdv));
      if (t == 0) d = f_win(tdv);
      if (t == 1) d = f_win(tdv) + 1;
      good = (d <= f_win(tdv));
      pgi_low = 1'b0; uv_flag = 1'b1; td_cycles = CW'(tdv);
      step();
      uv_flag = 1'b0;
      measure_on(m);
      chk("R4 random latency", m, f_lat(tdv));
      pb_seen = 1'b0;
      for (int j = 1; j <= f_win(tdv) + 2; j++) begin
        pgi_low = (j >= d);
        step();
        if (set_pb_flt) pb_seen = 1'b1;
      end
      chk("R7 random gate state", int'(gate_en), int'(good));
      chk("R8 random pb pulse", int'(pb_seen), int'(!good));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule